// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block takes characters from a host and sends each one as an asynchronous frame on a single serial output line. The host writes a character through a parallel port made of a data bus and a one-cycle write strobe. The character lands in a one-entry holding buffer. From there it moves into a shift register, which sends it one bit at a time. Two more inputs are sampled when each frame is loaded. A mode word sets the frame format: 5 to 8 data bits, optional odd or even parity, 1, 1.5 or 2 stop bits, and a bit time of 1, 16 or 64 transmit-clock periods. A command input carries an enable bit.

A new frame starts only when the enable bit is set and the peripheral holds its active-low clear-to-send input low. Two flags report progress to the host. The ready flag means the holding buffer can take another character. The empty flag means the holding buffer and the shift register are both idle.

All logic runs from the transmit clock. Host writes are taken on its rising edge. The serial line moves only on its falling edge.

Top module: `async_tx`

## Requirements
- R1: After reset, and whenever nothing is queued or being sent, `txd` is high. After reset, `tx_rdy` and `tx_empty` are both 1.
- R2: A frame is sent in this order: one low start bit, then the data bits least significant first, then the parity bit when enabled, then high stop bits.
- R3: The character length is `mode[3:2]` + 5 bits (5 to 8). Bits of `wr_data` above that length do not appear on the line.
- R4: `mode[4]` enables parity and `mode[5]` selects its sense (1 = even, 0 = odd). The count of ones across the sent data bits and the parity bit is even for even parity and odd for odd parity.
- R5: `mode[7:6]` sets the stop time: 0 gives 1 bit time, 1 gives 1.5 bit times, and 2 or 3 give 2 bit times. With a bit time of one clock, the 1.5 setting gives 2 clock periods.
- R6: `mode[1:0]` sets the bit time: 0 gives 1 transmit-clock period, 1 gives 16, and 2 or 3 give 64.
- R7: A frame begins only on a falling edge at which `cmd_txen` is 1 and `cts_n` is 0. A character held while either condition is false stays queued and `txd` stays high.
- R8: `tx_rdy` is 1 exactly when the holding buffer is free. A write made while `tx_rdy` is 0 is dropped.
- R9: `tx_empty` is 1 only when both the buffer and the shifter are idle. A queued character starts right after the previous stop time ends, with no extra idle time.
- R10: `txd` changes only on a falling edge of `txc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| txc | input | 1 | Transmit clock; host writes on rising edge, line updates on falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Character to send |
| mode | input | 8 | Frame format: [1:0] bit-time factor, [3:2] length-5, [4] parity enable, [5] even parity, [7:6] stop time |
| cmd_txen | input | 1 | Transmit enable command bit |
| cts_n | input | 1 | Clear to send from the peripheral, active low |
| txd | output | 1 | Serial data line, idle high |
| tx_rdy | output | 1 | Holding buffer free |
| tx_empty | output | 1 | Buffer and shifter both idle |

## Verification
The bench sends two characters back to back and measures the high gap between the two frames in clock periods. This exposes a stop time that is too long or too short, including the 1.5-stop setting at a bit time of one clock, where a design that failed to round up would send a single clock period of stop. Characters with bits set above the programmed length and with odd ones-counts expose a design that leaks upper bits onto the line or inverts the parity sense. Each such design gives a frame that does not match the bit-by-bit expectation. A character is written while transmission is disabled or clear-to-send is high, and then a second one while the buffer is full. A design that ignored the gate would start early. A design that accepted the second write would overwrite the first character or send an extra frame.

// File: rtl/async_tx.sv
module async_tx #(
  parameter int CNT_W = 8
) (
  input  logic       txc,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic [7:0] mode,
  input  logic       cmd_txen,
  input  logic       cts_n,
  output logic       txd,
  output logic       tx_rdy,
  output logic       tx_empty
);
  logic             wr_tgl, take_tgl;
  logic [7:0]       hold_q;
  logic             busy, in_stop, txd_q;
  logic [9:0]       shreg;
  logic [3:0]       slots;
  logic [CNT_W-1:0] tick, per_q, stop_q;

  wire hold_full = wr_tgl ^ take_tgl;

  always_ff @(posedge txc or negedge rst_n)
    if (!rst_n) begin
      wr_tgl <= 1'b0;
      hold_q <= '0;
    end else if (wr_en && !hold_full) begin
      wr_tgl <= ~wr_tgl;
      hold_q <= wr_data;
    end

  logic [3:0]       len;
  logic [7:0]       masked;
  logic             par;
  logic [9:0]       after_start;
  logic [CNT_W-1:0] period, stop_ticks;

  assign len    = 4'd5 + {2'b00, mode[3:2]};
  assign masked = hold_q & (8'hFF >> (4'd8 - len));
  assign par    = (^masked) ^ ~mode[5];

  always_comb begin
    after_start = '1;
    for (int i = 0; i < 8; i++)
      if (i < int'(len)) after_start[i] = masked[i];
    if (mode[4]) after_start[len] = par;
  end

  always_comb begin
    case (mode[1:0])
      2'd0:    period = CNT_W'(1);
      2'd1:    period = CNT_W'(16);
      default: period = CNT_W'(64);
    endcase
    case (mode[7:6])
      2'd0:    stop_ticks = period;
      2'd1:    stop_ticks = (mode[1:0] == 2'd0) ? CNT_W'(2) : period + (period >> 1);
      default: stop_ticks = period << 1;
    endcase
  end

  wire start_ok = hold_full && cmd_txen && !cts_n;
  wire can_load = !busy || (in_stop && tick == '0);

  always_ff @(negedge txc or negedge rst_n)
    if (!rst_n) begin
      busy     <= 1'b0;
      in_stop  <= 1'b0;
      txd_q    <= 1'b1;
      shreg    <= '1;
      slots    <= '0;
      tick     <= '0;
      per_q    <= '0;
      stop_q   <= '0;
      take_tgl <= 1'b0;
    end else if (can_load) begin
      if (start_ok) begin
        busy     <= 1'b1;
        in_stop  <= 1'b0;
        txd_q    <= 1'b0;
        shreg    <= after_start;
        slots    <= len + {3'b000, mode[4]};
        tick     <= period - CNT_W'(1);
        per_q    <= period;
        stop_q   <= stop_ticks;
        take_tgl <= ~take_tgl;
      end else begin
        busy    <= 1'b0;
        in_stop <= 1'b0;
        txd_q   <= 1'b1;
      end
    end else if (tick != '0) begin
      tick <= tick - CNT_W'(1);
    end else if (slots != '0) begin
      txd_q <= shreg[0];
      shreg <= {1'b1, shreg[9:1]};
      slots <= slots - 4'd1;
      tick  <= per_q - CNT_W'(1);
    end else begin
      in_stop <= 1'b1;
      txd_q   <= 1'b1;
      tick    <= stop_q - CNT_W'(1);
    end

  assign txd      = txd_q;
  assign tx_rdy   = !hold_full;
  assign tx_empty = !hold_full && !busy;
endmodule

// File: rtl/async_tx_chk.sv
module async_tx_chk (
  input logic txc,
  input logic rst_n,
  input logic wr_en,
  input logic cmd_txen,
  input logic cts_n,
  input logic txd,
  input logic tx_rdy,
  input logic tx_empty,
  input logic busy
);
  always @(txd)
    if (rst_n) p_txd_fall_r10: assert (!txc);

  p_idle_high_r1: assert property (@(posedge txc) disable iff (!rst_n)
    tx_empty |-> txd);

  p_empty_rdy_r9: assert property (@(posedge txc) disable iff (!rst_n)
    tx_empty |-> tx_rdy);

  p_rdy_hold_r8: assert property (@(posedge txc) disable iff (!rst_n)
    (tx_rdy && !wr_en) |=> tx_rdy);

  p_start_gate_r7: assert property (@(negedge txc) disable iff (!rst_n)
    $rose(busy) |-> ($past(cmd_txen) && !$past(cts_n)));

  p_shift_idle_r2: assert property (@(negedge txc) disable iff (!rst_n)
    !busy |-> txd);
endmodule

bind async_tx async_tx_chk i_chk (
  .txc(txc), .rst_n(rst_n), .wr_en(wr_en), .cmd_txen(cmd_txen), .cts_n(cts_n),
  .txd(txd), .tx_rdy(tx_rdy), .tx_empty(tx_empty), .busy(busy)
);

// File: tb/test_async_tx.sv
module test_async_tx;
  logic       clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, cmd_txen = 1'b1, cts_n = 1'b0;
  logic [7:0] wr_data = '0, mode = '0;
  logic       txd, tx_rdy, tx_empty;
  int checks = 0, errs = 0;

  async_tx i_async_tx (.txc(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .mode(mode), .cmd_txen(cmd_txen), .cts_n(cts_n), .txd(txd),
    .tx_rdy(tx_rdy), .tx_empty(tx_empty));

  always #2 clk = ~clk;

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic wait_start(string req);
    int n = 0;
    while (txd !== 1'b0 && n < 5000) begin step(); n++; end
    check(req, "frame start seen", int'(txd === 1'b0), 1);
  endtask

  function automatic int bit_time(int bd);
    return bd == 0 ? 1 : (bd == 1 ? 16 : 64);
  endfunction

  function automatic int stop_time(int st, int bd);
    int p = bit_time(bd);
    if (st == 0) return p;
    if (st == 1) return bd == 0 ? 2 : p + p / 2;
    return 2 * p;
  endfunction

  task automatic check_bits(string req, logic [7:0] d, int len, int pe, int ev, int p);
    logic exp_bits[10];
    int nb = 1 + len + pe, mis = 0, ones = 0;
    exp_bits[0] = 1'b0;
    for (int i = 0; i < len; i++) begin
      exp_bits[i+1] = d[i];
      ones += int'(d[i]);
    end
    if (pe != 0) exp_bits[len+1] = (ev != 0) ? logic'(ones % 2) : logic'(1 - ones % 2);
    for (int k = 0; k < nb * p; k++) begin
      if (txd !== exp_bits[k / p]) mis++;
      step();
    end
    check(req, "frame bit mismatches", mis, 0);
  endtask

  task automatic run_frame(string req, logic [7:0] d1, logic [7:0] d2,
                           int len, int pe, int ev, int st, int bd);
    int p = bit_time(bd), s = stop_time(st, bd), gap = 0, hi = 0;
    mode = {2'(st), 1'(ev), 1'(pe), 2'(len - 5), 2'(bd)};
    cmd_txen = 1'b1; cts_n = 1'b0;
    fork begin wr(d1); wr(d2); end join_none
    wait_start(req);
    check_bits(req, d1, len, pe, ev, p);
    while (txd === 1'b1 && gap < 400) begin gap++; step(); end
    check("R5", "stop gap between back-to-back frames", gap, s);
    check_bits(req, d2, len, pe, ev, p);
    for (int k = 0; k < s + 4; k++) begin hi += int'(txd === 1'b1); step(); end
    check("R9", "line high after last frame", hi, s + 4);
    check("R9", "empty after last frame", int'(tx_empty), 1);
  endtask

  task automatic gate_test();
    int lows = 0;
    mode = 8'b00_0_0_11_00;
    cmd_txen = 1'b0; cts_n = 1'b0;
    wr(8'h3C);
    check("R8", "ready after write", int'(tx_rdy), 0);
    wr(8'hC3);
    for (int k = 0; k < 20; k++) begin lows += int'(txd === 1'b0); step(); end
    check("R7", "no start while disabled", lows, 0);
    check("R9", "not empty with char queued", int'(tx_empty), 0);
    cmd_txen = 1'b1; cts_n = 1'b1;
    lows = 0;
    for (int k = 0; k < 20; k++) begin lows += int'(txd === 1'b0); step(); end
    check("R7", "no start while cts_n high", lows, 0);
    cts_n = 1'b0;
    wait_start("R7");
    check_bits("R8", 8'h3C, 8, 0, 0, 1);
    lows = 0;
    for (int k = 0; k < 30; k++) begin lows += int'(txd === 1'b0); step(); end
    check("R8", "write while full dropped", lows, 0);
    check("R1", "idle after frame", int'(tx_empty && tx_rdy), 1);
  endtask

  task automatic edge_test();
    int mis = 0;
    logic a;
    mode = 8'b00_0_1_11_00;
    fork wr(8'h5B); join_none
    for (int k = 0; k < 30; k++) begin
      @(negedge clk); #1; a = txd;
      @(posedge clk); #1;
      if (txd !== a) mis++;
    end
    check("R10", "txd moved around rising edge", mis, 0);
    repeat (20) step();
  endtask

  initial begin
    #(200000 * 4);
    checks++; errs++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    repeat (3) step();
    check("R1", "txd at reset", int'(txd), 1);
    check("R1", "ready at reset", int'(tx_rdy), 1);
    check("R1", "empty at reset", int'(tx_empty), 1);
    rst_n = 1'b1;
    step();
    run_frame("R2", 8'hA5, 8'h5A, 8, 0, 0, 0, 0);
    run_frame("R3", 8'hF3, 8'h8C, 7, 1, 1, 0, 1);
    run_frame("R4", 8'h35, 8'h0A, 5, 1, 0, 2, 0);
    run_frame("R5", 8'hC7, 8'h21, 6, 0, 0, 1, 1);
    run_frame("R5", 8'h81, 8'h7E, 8, 1, 0, 1, 0);
    run_frame("R6", 8'h96, 8'h69, 8, 0, 0, 0, 2);
    gate_test();
    edge_test();
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule